// File: doc/BRIEF.md
# Double-Buffered Eight-Channel Converter Code Bank

This block is the digital front end of an eight-channel, 13-bit converter. A host drives a parallel bus made of a 13-bit data word, a channel address and three active-low strobes: select, write and load. An active-low clear input is also present. Each channel holds two registers. The first stage takes a word from the bus. The second stage holds the code that the channel presents. Because a single load strobe moves every first-stage word into the second stage at once, all channels can change together.

The strobes are level-sensitive, but the block samples them on the rising edge of a system clock instead of building real latches. The clear input masks the outputs and leaves both register stages untouched. While clear is active, every channel reports its force-to-ground flag and a zero code. When clear is released, each channel returns to the code held in its second stage. Codes are offset binary and pass through the block without any change.

Top module: `dac_dbuf_bank`

## Requirements
- R1: The 3-bit address selects one channel, and the highest address bit is the most significant. Address value k selects channel k. Channel k's code appears on `chan_code_o[k*13 +: 13]`, so channel 0 sits in bits 12:0.
- R2: If select or write is high at a clock edge, every first-stage register keeps its value.
- R3: If select and write are both low at a clock edge, the addressed first-stage register takes the data word. The other seven registers do not change.
- R4: If load is low at a clock edge, every second-stage register takes the value of its first-stage register. If load is high, every second-stage register holds its value.
- R5: If select, write and load are all low at the same edge, the new data word appears on the addressed channel's output code after that edge, one cycle after sampling.
- R6: If clear is sampled low, all force flags read 1 and all codes read 0 from the next cycle on. Writes and loads still update both register stages during this time.
- R7: One cycle after clear is sampled high again, every channel presents the code held in its second-stage register.
- R8: A synchronous active-high reset sets both register stages of every channel to 0 and clears the force flags.
- R9: Codes are 13-bit offset binary and pass through unchanged: 0 (minimum), 4096 (mid-scale) and 8191 (full scale) appear exactly as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| ld_n | input | 1 | Active-low global load strobe |
| clr_n | input | 1 | Active-low output clear |
| addr_i | input | 3 | Channel address |
| data_i | input | 13 | Offset-binary data word |
| chan_code_o | output | 104 | Eight 13-bit channel codes, channel k at bits k*13 +: 13 |
| force_gnd_o | output | 8 | Per-channel force-to-ground flag |

## Verification
The bench builds the block with its default values: eight channels and 13-bit codes. These defaults let it cover every address value and the full-scale code 8191. A bench-side model of all sixteen registers predicts every channel code and force flag after each edge. The stimulus includes writes with load held off, global loads, partial strobes, write and load in the same cycle, writes and loads under clear, a reset in the middle of a run, and a stretch of random bus traffic.

// File: rtl/dacbank_pkg.sv
package dacbank_pkg;

    localparam int DEF_NUM_CH = 8;
    localparam int DEF_CODE_W = 13;

    // Sampled bus strobes, all active low
    typedef struct packed {
        logic sel_n;
        logic wr_n;
        logic ld_n;
        logic clr_n;
    } strobe_t;

    function automatic logic write_open(strobe_t s);
        return !s.sel_n && !s.wr_n;
    endfunction

    function automatic logic load_open(strobe_t s);
        return !s.ld_n;
    endfunction

endpackage

// File: rtl/dacbank_in_stage.sv
module dacbank_in_stage
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W,
    parameter int ADDR_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CODE_W-1:0] data,
    output logic [CODE_W-1:0] in_next [NUM_CH],
    output logic [CODE_W-1:0] in_q    [NUM_CH]
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit;

        always_comb begin
            hit        = wr_en && (addr == ADDR_W'(i));
            in_next[i] = hit ? data : in_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst) in_q[i] <= '0;
            else     in_q[i] <= in_next[i];
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
            (wr_en && addr == ADDR_W'(i)) |=> (in_q[i] == $past(data)))
            else $error("write did not land"); // R3

        AST_INPUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && addr == ADDR_W'(i)) |=> $stable(in_q[i]))
            else $error("unaddressed input register moved"); // R2
    end

endmodule

// File: rtl/dacbank_out_stage.sv
module dacbank_out_stage
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [CODE_W-1:0] in_next [NUM_CH],
    output logic [CODE_W-1:0] out_q   [NUM_CH]
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst)          out_q[i] <= '0;
            else if (load_en) out_q[i] <= in_next[i];
        end

        AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (rst)
            !load_en |=> $stable(out_q[i]))
            else $error("output register moved without load"); // R4
    end

endmodule

// File: rtl/dacbank_clear_mask.sv
module dacbank_clear_mask
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr_n,
    input  logic [CODE_W-1:0]        out_q [NUM_CH],
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [NUM_CH-1:0]        force_o
);

    logic force_q;

    always_ff @(posedge clk) begin
        if (rst) force_q <= 1'b0;
        else     force_q <= !clr_n;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign code_o[i*CODE_W +: CODE_W] = force_q ? '0 : out_q[i];
        assign force_o[i]                 = force_q;
    end

endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
    import dacbank_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W,
    localparam int ADDR_W = $clog2(NUM_CH),
    localparam int BUS_W  = NUM_CH * CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wr_n,
    input  logic              ld_n,
    input  logic              clr_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [CODE_W-1:0] data_i,
    output logic [BUS_W-1:0]  chan_code_o,
    output logic [NUM_CH-1:0] force_gnd_o
);

    strobe_t           stb;
    logic              wr_en;
    logic              load_en;
    logic [CODE_W-1:0] in_next [NUM_CH];
    logic [CODE_W-1:0] in_q    [NUM_CH];
    logic [CODE_W-1:0] out_q   [NUM_CH];

    always_comb begin
        stb     = '{sel_n: sel_n, wr_n: wr_n, ld_n: ld_n, clr_n: clr_n};
        wr_en   = write_open(stb);
        load_en = load_open(stb);
    end

    dacbank_in_stage #(.NUM_CH(NUM_CH), .CODE_W(CODE_W), .ADDR_W(ADDR_W)) u_in (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr_i), .data(data_i),
        .in_next(in_next), .in_q(in_q)
    );

    dacbank_out_stage #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_out (
        .clk(clk), .rst(rst), .load_en(load_en), .in_next(in_next), .out_q(out_q)
    );

    dacbank_clear_mask #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_mask (
        .clk(clk), .rst(rst), .clr_n(clr_n), .out_q(out_q),
        .code_o(chan_code_o), .force_o(force_gnd_o)
    );

    AST_RESET_ZEROES: assert property (@(posedge clk)
        rst |=> (chan_code_o == '0 && force_gnd_o == '0))
        else $error("reset left state behind"); // R8

    AST_CLEAR_FORCES: assert property (@(posedge clk) disable iff (rst)
        !clr_n |=> (force_gnd_o == '1 && chan_code_o == '0))
        else $error("clear did not force outputs"); // R6

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        AST_LOAD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
            !ld_n |=> (out_q[i] == in_q[i]))
            else $error("load did not copy input stage"); // R4

        AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
            (!sel_n && !wr_n && !ld_n && clr_n && addr_i == ADDR_W'(i))
            |=> (chan_code_o[i*CODE_W +: CODE_W] == $past(data_i)))
            else $error("same-cycle write and load did not pass through"); // R5

        AST_CLEAR_RESUMES: assert property (@(posedge clk) disable iff (rst)
            clr_n |=> (chan_code_o[i*CODE_W +: CODE_W] == out_q[i] && !force_gnd_o[i]))
            else $error("channel did not resume held code"); // R7
    end

endmodule

// File: tb/dac_dbuf_bank_tb.sv
module dac_dbuf_bank_tb;

    localparam int NCH = 8;
    localparam int CW  = 13;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              sel_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [2:0]        addr = '0;
    logic [CW-1:0]     data = '0;
    logic [NCH*CW-1:0] code;
    logic [NCH-1:0]    frc;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    int in_m  [NCH];
    int out_m [NCH];
    bit frc_m;

    dac_dbuf_bank u_dut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wr_n(wr_n), .ld_n(ld_n), .clr_n(clr_n),
        .addr_i(addr), .data_i(data), .chan_code_o(code), .force_gnd_o(frc)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic drive(input bit s, input bit w, input bit l, input bit c,
                         input int a, input int d);
        sel_n = s; wr_n = w; ld_n = l; clr_n = c;
        addr = 3'(a); data = CW'(d);
    endtask

    // one clock: update reference model with sampled inputs, then compare all channels
    task automatic cyc(input string tag);
        @(posedge clk);
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin in_m[i] = 0; out_m[i] = 0; end
            frc_m = 0;
        end else begin
            if (!sel_n && !wr_n) in_m[addr] = int'(data);
            if (!ld_n) for (int i = 0; i < NCH; i++) out_m[i] = in_m[i];
            frc_m = !clr_n;
        end
        #1;
        for (int i = 0; i < NCH; i++) begin
            chk(tag, int'(code[i*CW +: CW]), frc_m ? 0 : out_m[i]);
            chk(tag, int'(frc[i]), int'(frc_m));
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R8 reset state
        rst = 1'b1;
        cyc("R8");
        cyc("R8");
        #1 rst = 1'b0;

        // R1 R3: write each channel with load held off; outputs must stay zero (R4 hold)
        for (int k = 0; k < NCH; k++) begin
            drive(0, 0, 1, 1, k, 100 + 37 * k);
            cyc("R3");
        end
        drive(1, 1, 1, 1, 0, 0);
        cyc("R4");

        // R4 global load
        drive(1, 1, 0, 1, 0, 0);
        cyc("R4");
        for (int k = 0; k < NCH; k++)
            chk("R1", int'(code[k*CW +: CW]), 100 + 37 * k);
        drive(1, 1, 1, 1, 0, 0);
        cyc("R4");

        // R2 partial strobes ignored, then load shows input stage unchanged
        drive(1, 0, 1, 1, 3, 5555);
        cyc("R2");
        drive(0, 1, 1, 1, 4, 6666);
        cyc("R2");
        drive(1, 1, 0, 1, 0, 0);
        cyc("R2");
        chk("R2", int'(code[3*CW +: CW]), 100 + 37 * 3);
        chk("R2", int'(code[4*CW +: CW]), 100 + 37 * 4);

        // R5 write and load in the same cycle
        drive(0, 0, 0, 1, 6, 1234);
        cyc("R5");
        chk("R5", int'(code[6*CW +: CW]), 1234);
        drive(0, 0, 0, 1, 6, 4321);
        cyc("R5");
        chk("R5", int'(code[6*CW +: CW]), 4321);

        // R9 offset-binary codes pass unchanged
        drive(0, 0, 0, 1, 0, 0);    cyc("R9"); chk("R9", int'(code[0 +: CW]), 0);
        drive(0, 0, 0, 1, 2, 4096); cyc("R9"); chk("R9", int'(code[2*CW +: CW]), 4096);
        drive(0, 0, 0, 1, 7, 8191); cyc("R9"); chk("R9", int'(code[7*CW +: CW]), 8191);
        drive(1, 1, 1, 1, 0, 0);    cyc("R9");

        // R6 clear forces outputs; writes and loads continue underneath
        drive(1, 1, 1, 0, 0, 0);
        cyc("R6");
        chk("R6", int'(frc), 255);
        drive(0, 0, 1, 0, 5, 777);
        cyc("R6");
        drive(1, 1, 0, 0, 0, 0);
        cyc("R6");
        chk("R6", int'(code[5*CW +: CW]), 0);

        // R7 release clear: loaded value appears
        drive(1, 1, 1, 1, 0, 0);
        cyc("R7");
        chk("R7", int'(code[5*CW +: CW]), 777);
        chk("R7", int'(code[7*CW +: CW]), 8191);

        // random traffic
        for (int n = 0; n < 400; n++) begin
            int r;
            r = int'($urandom);
            drive(r[0], r[1], r[2] | r[3], r[4] | r[5] | r[6], r[9:7], r[22:10]);
            cyc("R4");
        end

        // R8 reset mid-run
        drive(1, 1, 1, 1, 0, 0);
        rst = 1'b1;
        cyc("R8");
        #1 rst = 1'b0;
        cyc("R8");
        chk("R8", int'(code), 0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule